// File: doc/BRIEF.md
# Nibble ALU with Carry and Condition Flag

This block is the arithmetic and logic unit of a small 4-bit controller. On each cycle it forms a result from an opcode, the accumulator, a memory operand, an immediate and a pointer register value. The result is combinational, so the surrounding datapath can write it back in the same cycle. The block also keeps two flag registers. The carry flag is an input to the carry-consuming operations. The condition flag is the input a conditional branch samples, and the branch is taken only when that flag is 1.

Each operation has its own rule for the condition flag. It may be the inverse of the carry, the carry itself (meaning no borrow), the non-zero state of the result, the inverse of a tested bit, a copy of the carry, or a constant 1. Only add-with-carry, reverse-subtract-with-borrow and the two explicit carry operations write the carry flag. The flags change only on a cycle where the execute strobe is high.

Top module: `nib_alu`

## Requirements
- R1: While reset is asserted and after it is released, before any execute strobe, the carry flag is 0 and the condition flag is 1.
- R2: The flags change only at a clock edge where `exec_en` is 1, and the new values are visible after that edge. With `exec_en` at 0 both flags hold. `res` follows the current inputs with no register stage.
- R3: Opcode 0 gives acc+mem and opcode 1 gives acc+imm, both modulo 16. The condition flag becomes the inverse of the carry out. The carry flag is unchanged.
- R4: Opcode 2 gives ptr+imm modulo 16 and uses the same flag rule as R3.
- R5: Opcode 3 gives acc+mem+carry. The carry flag takes the carry out, and the condition flag takes its inverse.
- R6: Opcode 4 gives mem−acc−(1−carry) modulo 16. The carry flag becomes 1 exactly when no borrow occurs, and the condition flag equals the new carry flag.
- R7: Opcode 5 gives mem+1, with the condition flag set to 1 unless mem is 15. Opcode 6 gives mem−1, with the condition flag set to 1 unless mem is 0. Neither changes the carry flag.
- R8: Opcodes 7, 8 and 9 give acc AND mem, acc OR mem and acc XOR mem. The condition flag is 1 when the result is non-zero. The carry flag is unchanged.
- R9: Opcode 10 sets the condition flag to the inverse of bit `bit_sel` of mem. `res` equals acc. The carry flag is unchanged.
- R10: Opcode 11 is a transfer. `res` equals mem, the condition flag is forced to 1 and the carry flag is unchanged.
- R11: Opcode 12 clears the carry flag and opcode 13 sets it. Both force the condition flag to 1, and `res` equals acc.
- R12: Opcode 14 copies the carry flag into the condition flag. Opcode 15 changes neither flag. Both leave the carry flag as it was, and `res` equals acc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Execute strobe; flags update only when high |
| op | input | 4 | Operation code |
| acc | input | W | Accumulator operand |
| mem | input | W | Memory operand |
| imm | input | W | Immediate operand |
| ptr | input | W | Pointer register operand |
| bit_sel | input | log2(W) | Bit index for the bit test |
| res | output | W | Combinational result |
| cf | output | 1 | Carry flag register |
| sf | output | 1 | Condition flag register, the branch condition |

## Verification
The result has no register, so the bench samples `res` 1 ns after it drives the inputs, inside the same cycle. Both flags are registered and are due one edge after the execute strobe. The bench drives at a falling edge and reads the flags at the following falling edge, after exactly one rising edge. The incoming carry and condition flags are set up through the block's own operations before each vector. Every opcode is then swept over all accumulator and memory values with both incoming carry states.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADDM = 4'd0,
    OP_ADDI = 4'd1,
    OP_ADDP = 4'd2,
    OP_ADDC = 4'd3,
    OP_SUBR = 4'd4,
    OP_INCM = 4'd5,
    OP_DECM = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_TSTB = 4'd10,
    OP_MOVE = 4'd11,
    OP_CLRC = 4'd12,
    OP_SETC = 4'd13,
    OP_TSTC = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/nib_alu_dp.sv
module nib_alu_dp
  import nib_alu_pkg::*;
#(
  parameter int W  = 4,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    mem,
  input  logic [W-1:0]    imm,
  input  logic [W-1:0]    ptr,
  input  logic [BW-1:0]   bit_sel,
  input  logic            cf_in,
  output logic [W-1:0]    res,
  output logic            cy,
  output logic            zero,
  output logic            tbit
);
  // One adder serves every arithmetic case; subtraction is x + ~y + ci,
  // whose carry out means "no borrow".
  function automatic logic [W:0] add_cy(input logic [W-1:0] x,
                                        input logic [W-1:0] y,
                                        input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  alu_op_e opc;
  logic [W:0] wide;

  assign opc = alu_op_e'(op);

  always_comb begin
    case (opc)
      OP_ADDM: wide = add_cy(acc, mem, 1'b0);
      OP_ADDI: wide = add_cy(acc, imm, 1'b0);
      OP_ADDP: wide = add_cy(ptr, imm, 1'b0);
      OP_ADDC: wide = add_cy(acc, mem, cf_in);
      OP_SUBR: wide = add_cy(mem, ~acc, cf_in);
      OP_INCM: wide = add_cy(mem, '0, 1'b1);
      OP_DECM: wide = add_cy(mem, '1, 1'b0);
      OP_AND:  wide = {1'b0, acc & mem};
      OP_OR:   wide = {1'b0, acc | mem};
      OP_XOR:  wide = {1'b0, acc ^ mem};
      OP_MOVE: wide = {1'b0, mem};
      default: wide = {1'b0, acc};
    endcase
  end

  assign res  = wide[W-1:0];
  assign cy   = wide[W];
  assign zero = (wide[W-1:0] == '0);
  assign tbit = mem[bit_sel];
endmodule

// File: rtl/nib_alu_flags.sv
module nib_alu_flags
  import nib_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [OP_W-1:0] op,
  input  logic            cy,
  input  logic            zero,
  input  logic            tbit,
  output logic            cf,
  output logic            sf
);
  alu_op_e opc;
  logic cf_nx, sf_nx;

  assign opc = alu_op_e'(op);

  always_comb begin
    cf_nx = cf;
    sf_nx = sf;
    case (opc)
      OP_ADDM, OP_ADDI, OP_ADDP, OP_INCM: sf_nx = ~cy;
      OP_ADDC: begin cf_nx = cy;   sf_nx = ~cy;  end
      OP_SUBR: begin cf_nx = cy;   sf_nx = cy;   end
      OP_DECM: sf_nx = cy;
      OP_AND, OP_OR, OP_XOR: sf_nx = ~zero;
      OP_TSTB: sf_nx = ~tbit;
      OP_MOVE: sf_nx = 1'b1;
      OP_CLRC: begin cf_nx = 1'b0; sf_nx = 1'b1; end
      OP_SETC: begin cf_nx = 1'b1; sf_nx = 1'b1; end
      OP_TSTC: sf_nx = cf;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf <= 1'b0;
      sf <= 1'b1;
    end else if (exec_en) begin
      cf <= cf_nx;
      sf <= sf_nx;
    end
  end

  a_r1_reset_flags: assert property (@(posedge clk)
    $rose(rst_n) |-> (cf == 1'b0 && sf == 1'b1));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> ($stable(cf) && $stable(sf)));

  a_r5_addc_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_ADDC) |=> (sf != cf));

  a_r6_subr_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_SUBR) |=> (sf == cf));

  // R3, R4, R7, R8, R9, R10, R12: carry flag untouched
  a_r7_cf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !(opc inside {OP_ADDC, OP_SUBR, OP_CLRC, OP_SETC}))
      |=> $stable(cf));

  a_r10_move_sf: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_MOVE) |=> sf);

  a_r11_setc: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_SETC) |=> (cf && sf));

  a_r11_clrc: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_CLRC) |=> (!cf && sf));

  a_r12_copy_cf: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_TSTC) |=> (sf == $past(cf)));

  a_r12_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_NOP) |=> ($stable(cf) && $stable(sf)));
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W  = 4,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    mem,
  input  logic [W-1:0]    imm,
  input  logic [W-1:0]    ptr,
  input  logic [BW-1:0]   bit_sel,
  output logic [W-1:0]    res,
  output logic            cf,
  output logic            sf
);
  logic dp_cy, dp_zero, dp_tbit;

  nib_alu_dp #(.W(W)) u_dp (
    .op      (op),
    .acc     (acc),
    .mem     (mem),
    .imm     (imm),
    .ptr     (ptr),
    .bit_sel (bit_sel),
    .cf_in   (cf),
    .res     (res),
    .cy      (dp_cy),
    .zero    (dp_zero),
    .tbit    (dp_tbit)
  );

  nib_alu_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (exec_en),
    .op      (op),
    .cy      (dp_cy),
    .zero    (dp_zero),
    .tbit    (dp_tbit),
    .cf      (cf),
    .sf      (sf)
  );

  a_r8_and_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |-> ((res & ~acc) == '0 && (res & ~mem) == '0));
endmodule

// File: tb/nib_alu_tb.sv
module nib_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [3:0] op = '0, acc = '0, mem = '0, imm = '0, ptr = '0;
  logic [1:0] bit_sel = '0;
  logic [3:0] res;
  logic       cf, sf;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  nib_alu #(.W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .acc(acc),
    .mem(mem), .imm(imm), .ptr(ptr), .bit_sel(bit_sel),
    .res(res), .cf(cf), .sf(sf)
  );

  function automatic string req_of(input int o);
    case (o)
      0, 1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7, 8, 9: return "R8";
      10: return "R9";
      11: return "R10";
      12, 13: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (op=%0d acc=%0d mem=%0d)",
               tag, what, act, exp, op, acc, mem);
    end
  endtask

  // Expected outputs computed with integer arithmetic
  task automatic model(input int o, input int a, input int m, input int i,
                       input int p, input int b, input int ci, input int si,
                       output int r, output int co, output int so);
    int t;
    co = ci; so = si; r = a;
    case (o)
      0: begin t = a + m; r = t % 16; so = (t < 16); end
      1: begin t = a + i; r = t % 16; so = (t < 16); end
      2: begin t = p + i; r = t % 16; so = (t < 16); end
      3: begin t = a + m + ci; r = t % 16; co = (t > 15); so = (t < 16); end
      4: begin t = m - a - (1 - ci); r = (t + 32) % 16; co = (t >= 0); so = co; end
      5: begin r = (m + 1) % 16; so = (m != 15); end
      6: begin r = (m + 15) % 16; so = (m != 0); end
      7: begin r = a & m; so = (r != 0); end
      8: begin r = a | m; so = (r != 0); end
      9: begin r = a ^ m; so = (r != 0); end
      10: so = (((m >> b) & 1) == 0);
      11: begin r = m; so = 1; end
      12: begin co = 0; so = 1; end
      13: begin co = 1; so = 1; end
      14: so = ci;
      default: ;
    endcase
  endtask

  // Bring flags to (c, s) through the block's own operations
  task automatic prep(input int c, input int s);
    @(negedge clk);
    exec_en = 1'b1; op = (c != 0) ? 4'd13 : 4'd12;
    @(negedge clk);
    if (s == 0) begin
      op = 4'd10; mem = 4'd1; bit_sel = 2'd0;
    end else begin
      exec_en = 1'b0;
    end
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int r, co, so;
    repeat (3) @(negedge clk);
    check("R1", "cf in reset", int'(cf), 0);
    check("R1", "sf in reset", int'(sf), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cf after reset", int'(cf), 0);
    check("R1", "sf after reset", int'(sf), 1);

    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 16; a++) begin
        for (int m = 0; m < 16; m++) begin
          for (int c = 0; c < 2; c++) begin
            int s, i, p, b;
            s = ((a ^ (m >> 3)) & 1);
            i = (m * 3 + a) % 16;
            p = a ^ m;
            b = (a + m) % 4;
            prep(c, s);
            exec_en = 1'b1; op = 4'(o); acc = 4'(a); mem = 4'(m);
            imm = 4'(i); ptr = 4'(p); bit_sel = 2'(b);
            model(o, a, m, i, p, b, c, s, r, co, so);
            #1;
            check(req_of(o), "res", int'(res), r);
            check("R2", "flags before edge", int'({cf, sf}), c * 2 + s);
            @(negedge clk);
            exec_en = 1'b0;
            check(req_of(o), "cf", int'(cf), co);
            check(req_of(o), "sf", int'(sf), so);
          end
        end
      end
    end

    // R2: with exec_en low every opcode leaves both flags alone
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 4; k++) begin
        prep(k & 1, k >> 1);
        op = 4'(o); acc = 4'(o + k); mem = 4'(15 - o); imm = 4'(k);
        ptr = 4'(o); bit_sel = 2'(k);
        @(negedge clk);
        check("R2", "cf idle", int'(cf), k & 1);
        check("R2", "sf idle", int'(sf), k >> 1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule